// File: doc/BRIEF.md
# Load/Store Byte-Lane Unit with Test IO Window

This block is the data-side access path of a small 32-bit core. Each cycle it can accept one request. A request carries a base register value, a signed 12-bit offset, a 3-bit size/sign code, store data and a read/write flag. The effective address is computed inside the block. Addresses below the IO base reach a word-wide local RAM. Stores there are steered onto byte lanes with per-byte write enables. Load words are narrowed to the requested width and sign- or zero-extended.

Stores at or above the IO base never touch RAM. They are decoded into three test-harness registers: a character sink, an integer sink and an exit request with a code. Any other address in that window is reported as an unknown IO access. All results appear one cycle after the request as single-cycle strobes with their data.

A small state machine tracks what the previous cycle accepted:
- `ST_IDLE`: no request was accepted last cycle.
- `ST_LOAD_RSP`: a load was accepted; a response is presented this cycle.
- `ST_STORE_DONE`: a store was accepted; IO strobes or an error may be presented this cycle.

From any state, the next state is chosen the same way:
- "take load" goes to `ST_LOAD_RSP`.
- "take store" goes to `ST_STORE_DONE`.
- "no request" goes to `ST_IDLE`.

Top module: `lsu_io_lane`

## Requirements
- R1: After reset, `rsp_valid`, `acc_err` and every `tbio_*` strobe are low, and all data outputs are zero.
- R2: The effective address is `req_base` plus `req_offset` sign-extended from bit 11, taken modulo 2^32.
- R3: Memory is little-endian: byte address A+i of a word lives in bits 8i+7:8i, so a word stored and bytes loaded back return its bytes in ascending order.
- R4: Load codes are 000 signed byte, 100 unsigned byte, 001 signed halfword, 101 unsigned halfword and 010 word. A halfword comes from bits 31:16 when address bit 1 is set and from bits 15:0 otherwise.
- R5: Every accepted load (`req_valid`=1, `req_write`=0) produces exactly one `rsp_valid` pulse in the following cycle, and `rsp_valid` is never high otherwise.
- R6: Store codes are 000 byte, 001 halfword and 010 word. A byte store changes only the lane chosen by address bits 1:0, a halfword store changes only the half chosen by address bit 1, and all other bytes keep their values.
- R7: A load code of 011, 110 or 111, or a store code other than 000/001/010, raises `acc_err` for one cycle in the following cycle. Such a load returns data 0, and such a store changes neither RAM nor any IO output.
- R8: Addresses below `IO_BASE` (default 0x80000000) select RAM word `addr[RAM_IDX_W+1:2]`, so the RAM aliases every `4*RAM_WORDS` bytes.
- R9: A valid store to `IO_BASE`+0x0 pulses `tbio_char_valid` with the low byte of the store data on `tbio_char`.
- R10: A valid store to `IO_BASE`+0x4 pulses `tbio_int_valid` with the full 32-bit store data on `tbio_int`.
- R11: A valid store to `IO_BASE`+0x8 pulses `tbio_exit_valid` with the store data on `tbio_exit_code`.
- R12: A valid store to any other address at or above `IO_BASE` pulses `tbio_unknown` and leaves RAM unchanged.
- R13: A load at or above `IO_BASE` with a valid code returns data 0 without error.
- R14: IO strobes appear only in the cycle after a store, at most one at a time, each for one cycle. Every data output is zero while its strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_base | input | 32 | Base register value |
| req_offset | input | 12 | Signed address offset |
| req_code | input | 3 | Size/sign code |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Load response strobe |
| rsp_data | output | 32 | Extended load data |
| acc_err | output | 1 | Invalid code strobe |
| tbio_char_valid | output | 1 | Character output strobe |
| tbio_char | output | 8 | Character value |
| tbio_int_valid | output | 1 | Integer output strobe |
| tbio_int | output | 32 | Integer value |
| tbio_exit_valid | output | 1 | Exit request strobe |
| tbio_exit_code | output | 32 | Exit code |
| tbio_unknown | output | 1 | Store to an undecoded IO address |

## Verification
The assertions assume that the inputs are stable and free of X while `req_valid` is high, and that `req_valid` is low throughout reset. They also assume that a misaligned halfword or word address is acceptable: the unit simply ignores the low address bits that do not select a lane. The bench drives every request on the falling edge and holds `req_valid` low during reset. Before any load it writes every RAM word, so no load ever reads uninitialised storage. Its randomised phase aims addresses at RAM words, at their aliases and at the IO window, with all eight codes.

// File: rtl/lsu_io_pkg.sv
package lsu_io_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_LOAD_RSP   = 2'd1,
        ST_STORE_DONE = 2'd2
    } lsu_state_e;

    typedef enum logic [2:0] {
        IO_NONE    = 3'd0,
        IO_CHAR    = 3'd1,
        IO_INT     = 3'd2,
        IO_EXIT    = 3'd3,
        IO_UNKNOWN = 3'd4
    } io_kind_e;

    localparam logic [2:0] CODE_BYTE   = 3'b000;
    localparam logic [2:0] CODE_HALF   = 3'b001;
    localparam logic [2:0] CODE_WORD   = 3'b010;
    localparam logic [2:0] CODE_BYTE_U = 3'b100;
    localparam logic [2:0] CODE_HALF_U = 3'b101;

    localparam logic [31:0] IO_OFS_CHAR = 32'h0;
    localparam logic [31:0] IO_OFS_INT  = 32'h4;
    localparam logic [31:0] IO_OFS_EXIT = 32'h8;

endpackage

// File: rtl/lsu_addr_decode.sv
module lsu_addr_decode
    import lsu_io_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          OFFW      = 12,
    parameter int          RAM_IDX_W = 6,
    parameter logic [31:0] IO_BASE   = 32'h8000_0000
) (
    input  logic [AW-1:0]        base,
    input  logic [OFFW-1:0]      offset,
    output logic [AW-1:0]        ea,
    output logic                 is_io,
    output io_kind_e             kind,
    output logic [RAM_IDX_W-1:0] ram_idx,
    output logic [1:0]           lane
);
    localparam int EXTW = AW - OFFW;

    logic [AW-1:0] io_off;

    always_comb begin
        ea      = base + {{EXTW{offset[OFFW-1]}}, offset};
        is_io   = (ea >= IO_BASE);
        io_off  = ea - IO_BASE;
        ram_idx = ea[RAM_IDX_W+1:2];
        lane    = ea[1:0];
        if (!is_io)                    kind = IO_NONE;
        else if (io_off == IO_OFS_CHAR) kind = IO_CHAR;
        else if (io_off == IO_OFS_INT)  kind = IO_INT;
        else if (io_off == IO_OFS_EXIT) kind = IO_EXIT;
        else                            kind = IO_UNKNOWN;
    end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_io_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2:0]      code,
    input  logic [1:0]      lane,
    input  logic [DW-1:0]   wdata,
    output logic [DW/8-1:0] be,
    output logic [DW-1:0]   wword,
    output logic            code_ok
);
    localparam int NB = DW / 8;
    localparam int NH = NB / 2;

    logic [DW-1:0] rep_byte;
    logic [DW-1:0] rep_half;

    for (genvar g = 0; g < NB; g++) begin : g_rep_b
        assign rep_byte[8*g +: 8] = wdata[7:0];
    end
    for (genvar g = 0; g < NH; g++) begin : g_rep_h
        assign rep_half[16*g +: 16] = wdata[15:0];
    end

    always_comb begin
        be      = '0;
        wword   = wdata;
        code_ok = 1'b1;
        unique case (code)
            CODE_BYTE: begin
                be[lane] = 1'b1;
                wword    = rep_byte;
            end
            CODE_HALF: begin
                be[{lane[1], 1'b0}] = 1'b1;
                be[{lane[1], 1'b1}] = 1'b1;
                wword               = rep_half;
            end
            CODE_WORD: be = '1;
            default:   code_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_io_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2:0]    code,
    input  logic [1:0]    lane,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] data,
    output logic          code_ok
);
    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_comb begin
        sel_b   = word[8*lane +: 8];
        sel_h   = lane[1] ? word[31:16] : word[15:0];
        data    = '0;
        code_ok = 1'b1;
        unique case (code)
            CODE_BYTE:   data = {{(DW-8){sel_b[7]}}, sel_b};
            CODE_BYTE_U: data = {{(DW-8){1'b0}}, sel_b};
            CODE_HALF:   data = {{(DW-16){sel_h[15]}}, sel_h};
            CODE_HALF_U: data = {{(DW-16){1'b0}}, sel_h};
            CODE_WORD:   data = word;
            default:     code_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsu_word_ram.sv
module lsu_word_ram #(
    parameter int WORDS = 64,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic                     re,
    input  logic [$clog2(WORDS)-1:0] idx,
    input  logic [DW/8-1:0]          be,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);
    localparam int NB = DW / 8;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < NB; b++) begin
                if (be[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
        if (re) rdata <= mem[idx];
    end
endmodule

// File: rtl/lsu_io_lane.sv
module lsu_io_lane
    import lsu_io_pkg::*;
#(
    parameter int          RAM_WORDS = 64,
    parameter logic [31:0] IO_BASE   = 32'h8000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_base,
    input  logic [11:0] req_offset,
    input  logic [2:0]  req_code,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic        acc_err,
    output logic        tbio_char_valid,
    output logic [7:0]  tbio_char,
    output logic        tbio_int_valid,
    output logic [31:0] tbio_int,
    output logic        tbio_exit_valid,
    output logic [31:0] tbio_exit_code,
    output logic        tbio_unknown
);
    localparam int DW        = 32;
    localparam int NB        = DW / 8;
    localparam int RAM_IDX_W = $clog2(RAM_WORDS);

    lsu_state_e state, state_nx;

    logic [31:0]          ea;
    logic                 is_io;
    io_kind_e             kind;
    logic [RAM_IDX_W-1:0] ram_idx;
    logic [1:0]           lane;
    logic [NB-1:0]        st_be;
    logic [DW-1:0]        st_word;
    logic                 st_ok;
    logic [DW-1:0]        ram_q;
    logic [DW-1:0]        ld_data;
    logic                 ld_ok;
    logic                 ram_we, ram_re;

    logic [2:0]  r_code;
    logic [1:0]  r_lane;
    logic        r_ld_io;
    logic        r_st_bad;
    io_kind_e    r_kind;
    logic [31:0] r_wdata;

    lsu_addr_decode #(
        .AW(32), .OFFW(12), .RAM_IDX_W(RAM_IDX_W), .IO_BASE(IO_BASE)
    ) u_dec (
        .base(req_base), .offset(req_offset), .ea(ea), .is_io(is_io),
        .kind(kind), .ram_idx(ram_idx), .lane(lane)
    );

    lsu_store_lanes #(.DW(DW)) u_st (
        .code(req_code), .lane(lane), .wdata(req_wdata),
        .be(st_be), .wword(st_word), .code_ok(st_ok)
    );

    assign ram_we = req_valid &&  req_write && !is_io && st_ok;
    assign ram_re = req_valid && !req_write && !is_io;

    lsu_word_ram #(.WORDS(RAM_WORDS), .DW(DW)) u_ram (
        .clk(clk), .we(ram_we), .re(ram_re), .idx(ram_idx),
        .be(st_be), .wdata(st_word), .rdata(ram_q)
    );

    lsu_load_extract #(.DW(DW)) u_ld (
        .code(r_code), .lane(r_lane), .word(ram_q),
        .data(ld_data), .code_ok(ld_ok)
    );

    // next state: the same three transitions leave every state
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_LOAD_RSP, ST_STORE_DONE: begin
                if (req_valid) state_nx = req_write ? ST_STORE_DONE : ST_LOAD_RSP;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request fields held for the response cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_code   <= '0;
            r_lane   <= '0;
            r_ld_io  <= 1'b0;
            r_st_bad <= 1'b0;
            r_kind   <= IO_NONE;
            r_wdata  <= '0;
        end else if (req_valid) begin
            r_code   <= req_code;
            r_lane   <= lane;
            r_ld_io  <= is_io;
            r_st_bad <= req_write && !st_ok;
            r_kind   <= (req_write && st_ok) ? kind : IO_NONE;
            r_wdata  <= req_wdata;
        end
    end

    always_comb begin
        rsp_valid       = 1'b0;
        rsp_data        = '0;
        acc_err         = 1'b0;
        tbio_char_valid = 1'b0;
        tbio_char       = '0;
        tbio_int_valid  = 1'b0;
        tbio_int        = '0;
        tbio_exit_valid = 1'b0;
        tbio_exit_code  = '0;
        tbio_unknown    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LOAD_RSP: begin
                rsp_valid = 1'b1;
                acc_err   = !ld_ok;
                if (ld_ok && !r_ld_io) rsp_data = ld_data;
            end
            ST_STORE_DONE: begin
                acc_err = r_st_bad;
                unique case (r_kind)
                    IO_CHAR: begin
                        tbio_char_valid = 1'b1;
                        tbio_char       = r_wdata[7:0];
                    end
                    IO_INT: begin
                        tbio_int_valid = 1'b1;
                        tbio_int       = r_wdata;
                    end
                    IO_EXIT: begin
                        tbio_exit_valid = 1'b1;
                        tbio_exit_code  = r_wdata;
                    end
                    IO_UNKNOWN: tbio_unknown = 1'b1;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lsu_io_lane_chk.sv
module lsu_io_lane_chk #(
    parameter logic [31:0] IO_BASE = 32'h8000_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [31:0] req_base,
    input logic [11:0] req_offset,
    input logic [2:0]  req_code,
    input logic [31:0] req_wdata,
    input logic        rsp_valid,
    input logic [31:0] rsp_data,
    input logic        acc_err,
    input logic        tbio_char_valid,
    input logic [7:0]  tbio_char,
    input logic        tbio_int_valid,
    input logic [31:0] tbio_int,
    input logic        tbio_exit_valid,
    input logic [31:0] tbio_exit_code,
    input logic        tbio_unknown
);
    logic [31:0] ea_c;
    logic        any_io;
    assign ea_c   = req_base + {{20{req_offset[11]}}, req_offset};
    assign any_io = tbio_char_valid | tbio_int_valid | tbio_exit_valid | tbio_unknown;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !rsp_valid && !acc_err && !any_io); // R1
    AST_LOAD_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rsp_valid); // R5
    AST_RSP_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R5
    AST_UBYTE_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_code) == 3'b100 |-> rsp_data[31:8] == 24'h0); // R4
    AST_BAD_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && acc_err |-> rsp_data == 32'h0); // R7
    AST_CHAR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        tbio_char_valid |-> $past(ea_c) == IO_BASE); // R9
    AST_INT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        tbio_int_valid |-> tbio_int == $past(req_wdata)); // R10
    AST_EXIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        tbio_exit_valid |-> tbio_exit_code == $past(req_wdata)); // R11
    AST_IO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tbio_char_valid, tbio_int_valid, tbio_exit_valid, tbio_unknown})); // R14
    AST_IO_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        any_io |-> $past(req_valid && req_write)); // R14
    AST_CHAR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !tbio_char_valid |-> tbio_char == 8'h0); // R14
endmodule

bind lsu_io_lane lsu_io_lane_chk #(.IO_BASE(IO_BASE)) chk_i (.*);

// File: tb/lsu_io_lane_tb_top.sv
`timescale 1ns/1ps
module lsu_io_lane_tb_top;
    localparam int          WORDS   = 64;
    localparam int          NBYTES  = WORDS * 4;
    localparam logic [31:0] IO_BASE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_base = '0, req_wdata = '0;
    logic [11:0] req_offset = '0;
    logic [2:0]  req_code = '0;
    logic        rsp_valid, acc_err, tbio_char_valid, tbio_int_valid, tbio_exit_valid, tbio_unknown;
    logic [31:0] rsp_data, tbio_int, tbio_exit_code;
    logic [7:0]  tbio_char;

    always #2 clk = ~clk;

    lsu_io_lane #(.RAM_WORDS(WORDS), .IO_BASE(IO_BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_base(req_base), .req_offset(req_offset), .req_code(req_code),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .acc_err(acc_err), .tbio_char_valid(tbio_char_valid), .tbio_char(tbio_char),
        .tbio_int_valid(tbio_int_valid), .tbio_int(tbio_int),
        .tbio_exit_valid(tbio_exit_valid), .tbio_exit_code(tbio_exit_code),
        .tbio_unknown(tbio_unknown)
    );

    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] mem_b [NBYTES];

    logic        e_rv, e_err, e_cv, e_iv, e_xv, e_uk;
    logic [31:0] e_rd, e_int, e_exit;
    logic [7:0]  e_ch;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_bytes(input logic [31:0] a, input int n);
        logic [31:0] v = '0;
        for (int i = 0; i < n; i++) v[8*i +: 8] = mem_b[(a + i) % NBYTES];
        return v;
    endfunction

    // behavioural model of one request; sets expectations for the next cycle
    task automatic model(input logic v, input logic w, input logic [31:0] b,
                         input logic [11:0] o, input logic [2:0] c, input logic [31:0] d);
        logic [31:0] ea, h;
        logic ld_ok, st_ok;
        {e_rv, e_err, e_cv, e_iv, e_xv, e_uk} = '0;
        e_rd = '0; e_int = '0; e_exit = '0; e_ch = '0;
        if (!v) return;
        ea    = b + {{20{o[11]}}, o};
        ld_ok = (c == 3'b000) || (c == 3'b001) || (c == 3'b010) || (c == 3'b100) || (c == 3'b101);
        st_ok = (c == 3'b000) || (c == 3'b001) || (c == 3'b010);
        if (!w) begin
            e_rv = 1'b1;
            if (!ld_ok) e_err = 1'b1;
            else if (ea < IO_BASE) begin
                case (c)
                    3'b000: begin h = rd_bytes(ea, 1); e_rd = {{24{h[7]}}, h[7:0]}; end
                    3'b100: e_rd = rd_bytes(ea, 1);
                    3'b001: begin h = rd_bytes(ea & ~32'h1, 2); e_rd = {{16{h[15]}}, h[15:0]}; end
                    3'b101: e_rd = rd_bytes(ea & ~32'h1, 2);
                    default: e_rd = rd_bytes(ea & ~32'h3, 4);
                endcase
            end
        end else if (!st_ok) e_err = 1'b1;
        else if (ea >= IO_BASE) begin
            if (ea - IO_BASE == 0)      begin e_cv = 1; e_ch = d[7:0]; end
            else if (ea - IO_BASE == 4) begin e_iv = 1; e_int = d; end
            else if (ea - IO_BASE == 8) begin e_xv = 1; e_exit = d; end
            else e_uk = 1;
        end else begin
            case (c)
                3'b000: mem_b[ea % NBYTES] = d[7:0];
                3'b001: for (int i = 0; i < 2; i++) mem_b[((ea & ~32'h1) + i) % NBYTES] = d[8*i +: 8];
                default: for (int i = 0; i < 4; i++) mem_b[((ea & ~32'h3) + i) % NBYTES] = d[8*i +: 8];
            endcase
        end
    endtask

    // called at a falling edge: drive, let one rising edge pass, compare at the next falling edge
    task automatic step(input logic v, input logic w, input logic [31:0] b, input logic [11:0] o,
                        input logic [2:0] c, input logic [31:0] d, input string tag);
        req_valid = v; req_write = w; req_base = b; req_offset = o; req_code = c; req_wdata = d;
        model(v, w, b, o, c, d);
        @(posedge clk);
        @(negedge clk);
        chk(tag, "rsp_valid", 32'(rsp_valid), 32'(e_rv));
        chk(tag, "rsp_data", rsp_data, e_rd);
        chk(tag, "acc_err", 32'(acc_err), 32'(e_err));
        chk(tag, "char_valid", 32'(tbio_char_valid), 32'(e_cv));
        chk(tag, "char", 32'(tbio_char), 32'(e_ch));
        chk(tag, "int_valid", 32'(tbio_int_valid), 32'(e_iv));
        chk(tag, "int", tbio_int, e_int);
        chk(tag, "exit_valid", 32'(tbio_exit_valid), 32'(e_xv));
        chk(tag, "exit_code", tbio_exit_code, e_exit);
        chk(tag, "unknown", 32'(tbio_unknown), 32'(e_uk));
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, '0, '0, '0, '0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        chk("R1", "rsp_valid", 32'(rsp_valid), 0);
        chk("R1", "acc_err", 32'(acc_err), 0);
        chk("R1", "io strobes", 32'({tbio_char_valid, tbio_int_valid, tbio_exit_valid, tbio_unknown}), 0);
        chk("R1", "data", rsp_data | tbio_int | tbio_exit_code | 32'(tbio_char), 0);

        for (int i = 0; i < WORDS; i++) step(1, 1, 32'(4 * i), 12'h0, 3'b010, 32'h0, "R8");

        // R3: little-endian byte order
        step(1, 1, 32'h10, 12'h0, 3'b010, 32'h4433_2211, "R3");
        for (int i = 0; i < 4; i++) step(1, 0, 32'h10, 12'(i), 3'b100, '0, "R3");
        // R4: every load code, sign and half selection
        step(1, 1, 32'h20, 12'h0, 3'b010, 32'h80FF_7F01, "R4");
        step(1, 0, 32'h23, 12'h0, 3'b000, '0, "R4");
        step(1, 0, 32'h23, 12'h0, 3'b100, '0, "R4");
        step(1, 0, 32'h21, 12'h0, 3'b000, '0, "R4");
        step(1, 0, 32'h22, 12'h0, 3'b001, '0, "R4");
        step(1, 0, 32'h22, 12'h0, 3'b101, '0, "R4");
        step(1, 0, 32'h20, 12'h0, 3'b001, '0, "R4");
        step(1, 0, 32'h20, 12'h0, 3'b010, '0, "R4");
        // R2: negative offset and address wrap
        step(1, 1, 32'h104, 12'hFFC, 3'b010, 32'hCAFE_F00D, "R2");
        step(1, 0, 32'hF8, 12'h008, 3'b010, '0, "R2");
        step(1, 0, 32'hFFFF_FFFC, 12'h104, 3'b010, '0, "R2");
        // R6: narrow stores touch only their lanes
        step(1, 1, 32'h31, 12'h0, 3'b000, 32'hFFFF_FFAA, "R6");
        step(1, 1, 32'h36, 12'h0, 3'b001, 32'h1234_BEEF, "R6");
        step(1, 0, 32'h30, 12'h0, 3'b010, '0, "R6");
        step(1, 0, 32'h34, 12'h0, 3'b010, '0, "R6");
        // R8: alias across RAM size
        step(1, 1, 32'(NBYTES + 8), 12'h0, 3'b010, 32'h5A5A_0001, "R8");
        step(1, 0, 32'h8, 12'h0, 3'b010, '0, "R8");
        // R7: invalid codes
        step(1, 0, 32'h8, 12'h0, 3'b011, '0, "R7");
        step(1, 0, 32'h8, 12'h0, 3'b111, '0, "R7");
        step(1, 1, 32'h8, 12'h0, 3'b110, 32'hDEAD_DEAD, "R7");
        step(1, 1, IO_BASE, 12'h0, 3'b100, 32'h41, "R7");
        step(1, 0, 32'h8, 12'h0, 3'b010, '0, "R7");
        // R9..R13: IO window
        step(1, 1, IO_BASE, 12'h0, 3'b010, 32'h1234_5648, "R9");
        step(1, 1, IO_BASE, 12'h4, 3'b010, 32'h89AB_CDEF, "R10");
        step(1, 1, IO_BASE + 8, 12'h0, 3'b010, 32'h0000_0007, "R11");
        step(1, 1, IO_BASE, 12'hC, 3'b010, 32'h1111_2222, "R12");
        step(1, 1, 32'h0, 12'h0, 3'b010, 32'h0, "R12");
        step(1, 1, IO_BASE, 12'h0, 3'b010, 32'hFFFF_FFFF, "R12");
        step(1, 0, 32'h0, 12'h0, 3'b010, '0, "R12");
        step(1, 0, IO_BASE, 12'h4, 3'b010, '0, "R13");
        // R5/R14: back-to-back then idle
        step(1, 0, 32'h10, 12'h0, 3'b010, '0, "R5");
        step(1, 0, 32'h14, 12'h0, 3'b010, '0, "R5");
        idle("R5");
        idle("R14");

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] tgt, bs;
            logic [11:0] of;
            case ($urandom_range(0, 3))
                0, 1:    tgt = 32'($urandom_range(0, 2 * NBYTES - 1));
                2:       tgt = IO_BASE + 32'(4 * $urandom_range(0, 4));
                default: tgt = IO_BASE + $urandom_range(0, 255);
            endcase
            of = 12'($urandom);
            bs = tgt - {{20{of[11]}}, of};
            step(1'($urandom_range(0, 4) != 0), 1'($urandom), bs, of, 3'($urandom),
                 $urandom, "R14");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R5 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule